// File: doc/BRIEF.md
# Bit-Serial Variable Node Processor

This block is the variable-side processing element of a fully parallel min-sum decoder for low-density parity-check codes. One instance serves one code bit. It holds the channel log-likelihood value of that bit for each of two interleaved frames. Every slot of `MSG_W` clock cycles it exchanges one serial message per edge with its neighbouring check nodes. For each edge it returns the sum of the channel value and the messages on all of its other edges. It also keeps a hard decision for each frame, taken from the sum over all edges.

Messages on the links travel most significant bit first, in sign-magnitude form. Inside the node, each captured message is read back least significant bit first as a two's-complement value. It is then added by a column-serial adder that carries a small guard-bit accumulator. After addition, the result is clipped to the symmetric link range and written back into the same shift register that received the message. The slot after that shifts the result out while the next message shifts in. Two register banks, selected by the slot parity, let one frame's messages arrive while the other frame's messages are summed.

A small sequencer has three states. `ST_HEAD` is the first bit cycle of a slot. `ST_BODY` covers the middle bit cycles. `ST_TAIL` is the last bit cycle. Its transitions are:
- T_START: `ST_HEAD` to `ST_BODY`.
- T_STEP: `ST_BODY` to `ST_BODY`, while middle bits remain.
- T_LAST: `ST_BODY` to `ST_TAIL`.
- T_WRAP: `ST_TAIL` to `ST_HEAD`, which also flips the bank side.

Top module: `bsvn_node`

## Requirements
- R1: After reset every outgoing line is 0 and both hard-decision bits are 0. Until results of real input arrive, every outgoing message reads as zero.
- R2: Slots are `MSG_W` cycles long, and the bank side alternates every slot, starting at 0 after reset. The messages captured on the edge lines during slot n are answered on the same edge lines during slot n+2.
- R3: Outside a fresh slot, the answer on edge e is the latched channel value plus every message captured in the slot except the one on edge e.
- R4: `frame_go` high in the first cycle of a slot latches `llr_in` for that slot's side and marks the slot fresh. The messages captured in a fresh slot are ignored, and every edge is answered with the channel value. `llr_in` has no effect in any other slot.
- R5: All messages, `llr_in` and answers are sign-magnitude. Bit `MSG_W-1` is the sign, and 1 means negative. Lines carry the sign bit first. A negative zero input counts as 0, and no answer is ever a negative zero.
- R6: Answers saturate to plus or minus (2^(MSG_W-1)-1), which is ±7 by default. A sum of exactly -8 is answered as -7.
- R7: `hard_dec[s]` is 1 when the full, unclipped sum of the channel value and all captured messages for side s is negative. It is updated at the same time as that side's answers become visible. A zero sum gives 0.
- R8: While `en` is low, all outgoing lines read 0. No message, channel value, fresh mark or hard decision changes, and `frame_go` is ignored. The slot sequencer keeps running.
- R9: The two sides are independent. A frame start on one side leaves the other side's channel value and answers untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Activity enable from termination logic; low freezes the node |
| frame_go | input | 1 | Frame start, sampled in the first cycle of a slot |
| llr_in | input | MSG_W | Channel value, sign-magnitude |
| c2v_bit | input | DEG | One serial incoming message bit per edge, sign first |
| v2c_bit | output | DEG | One serial outgoing message bit per edge, sign first |
| hard_dec | output | 2 | Hard decision per side |

## Verification
The bench builds the node with degree 4 and 4-bit messages, the configuration the slot timing is laid out for. At this size the column adders see sums from -10 to +31. That range brings positive and negative clipping within reach, including the single value -8 that only clipping can represent. Negative-zero messages and channel values are also exercised. Alternating frame starts on both sides show that the banks do not mix. A frozen stretch with a pending frame start shows that nothing latches while the node is disabled.

// File: rtl/bsvn_pkg.sv
package bsvn_pkg;

    // Position of the current cycle inside a message slot
    typedef enum logic [1:0] {
        ST_HEAD = 2'd0,
        ST_BODY = 2'd1,
        ST_TAIL = 2'd2
    } slot_st_e;

endpackage

// File: rtl/bsvn_slot_fsm.sv
module bsvn_slot_fsm
    import bsvn_pkg::*;
#(
    parameter int MSG_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output slot_st_e                  st,
    output logic                      side,
    output logic [$clog2(MSG_W)-1:0]  bit_idx
);

    localparam int IW = $clog2(MSG_W);

    slot_st_e        st_q, st_nx;
    logic            side_q, side_nx;
    logic [IW-1:0]   cnt_q, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_HEAD;
            side_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            st_q   <= st_nx;
            side_q <= side_nx;
            cnt_q  <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        st_nx   = st_q;
        side_nx = side_q;
        cnt_nx  = cnt_q;
        unique case (st_q)
            ST_HEAD: begin
                cnt_nx = IW'(1);
                st_nx  = (MSG_W > 2) ? ST_BODY : ST_TAIL;      // T_START
            end
            ST_BODY: begin
                cnt_nx = cnt_q + 1'b1;
                st_nx  = (cnt_q == IW'(MSG_W-2)) ? ST_TAIL : ST_BODY; // T_LAST / T_STEP
            end
            ST_TAIL: begin
                cnt_nx  = '0;
                side_nx = ~side_q;
                st_nx   = ST_HEAD;                              // T_WRAP
            end
            default: begin
                cnt_nx = '0;
                st_nx  = ST_HEAD;
            end
        endcase
    end

    // outputs
    always_comb begin
        st      = st_q;
        side    = side_q;
        bit_idx = cnt_q;
    end

    AST_SIDE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TAIL) |=> (side_q != $past(side_q)));            // R2
    AST_SIDE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_TAIL) |=> $stable(side_q));                      // R2
    AST_TAIL_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TAIL) |-> (cnt_q == IW'(MSG_W-1)));               // R2

endmodule

// File: rtl/bsvn_col_add.sv
module bsvn_col_add
    import bsvn_pkg::*;
#(
    parameter int NOPS  = 4,
    parameter int MSG_W = 4,
    parameter int SW    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  slot_st_e          st,
    input  logic [NOPS-1:0]   op_bits,
    output logic [MSG_W-1:0]  res_sm,
    output logic              neg
);

    localparam int LW = MSG_W - 1;

    logic signed [SW-1:0] carry_q, cin, col_s;
    logic        [SW-1:0] pop;
    logic        [LW-1:0] lo_q, nmag;

    // column population of the current bit weight
    always_comb begin
        pop = '0;
        for (int k = 0; k < NOPS; k++) pop = pop + SW'(op_bits[k]);
    end

    // sign-weight column subtracts; others add
    always_comb begin
        cin   = (st == ST_HEAD) ? '0 : carry_q;
        col_s = (st == ST_TAIL) ? (cin - $signed(pop)) : (cin + $signed(pop));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= '0;
            lo_q    <= '0;
        end else if (en && st != ST_TAIL) begin
            carry_q <= col_s >>> 1;
            lo_q    <= {col_s[0], lo_q[LW-1:1]};
        end
    end

    // value = col_s * 2^LW + lo_q, clipped and turned into sign-magnitude
    always_comb begin
        nmag = (~lo_q) + 1'b1;
        neg  = col_s[SW-1];
        if (col_s == '0)
            res_sm = {1'b0, lo_q};
        else if (!neg)
            res_sm = {1'b0, {LW{1'b1}}};
        else if (col_s == {SW{1'b1}} && lo_q != '0)
            res_sm = {1'b1, nmag};
        else
            res_sm = {1'b1, {LW{1'b1}}};
    end

    AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == ST_TAIL) |-> (res_sm != {1'b1, {LW{1'b0}}}));    // R5
    AST_CARRY_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_HEAD) |-> !carry_q[SW-1]);                          // R3

endmodule

// File: rtl/bsvn_node.sv
module bsvn_node
    import bsvn_pkg::*;
#(
    parameter int DEG   = 4,
    parameter int MSG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              frame_go,
    input  logic [MSG_W-1:0]  llr_in,
    input  logic [DEG-1:0]    c2v_bit,
    output logic [DEG-1:0]    v2c_bit,
    output logic [1:0]        hard_dec
);

    localparam int LW = MSG_W - 1;
    localparam int IW = $clog2(MSG_W);
    localparam int SW = $clog2(2*DEG + 4) + 1;

    slot_st_e          st;
    logic              side, abank;
    logic [IW-1:0]     bit_idx;

    logic [MSG_W-1:0]  msg_q [2][DEG];
    logic [MSG_W-1:0]  llr_q [2];
    logic [1:0]        fresh_q, hard_q;

    logic [MSG_W-1:0]  llr_tc;
    logic [MSG_W-1:0]  msg_tc [DEG];
    logic              llr_bit;
    logic [DEG-1:0]    msg_bit;
    logic [DEG-1:0]    edge_ops [DEG];
    logic [MSG_W-1:0]  edge_res [DEG];
    logic [DEG-1:0]    edge_neg;
    logic [MSG_W-1:0]  tot_res;
    logic              tot_neg;

    function automatic logic [MSG_W-1:0] sm_to_tc(input logic [MSG_W-1:0] sm);
        logic [MSG_W-1:0] mag;
        mag = {1'b0, sm[LW-1:0]};
        return sm[MSG_W-1] ? ((~mag) + 1'b1) : mag;
    endfunction

    bsvn_slot_fsm #(.MSG_W(MSG_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .st      (st),
        .side    (side),
        .bit_idx (bit_idx)
    );

    assign abank = ~side;

    // LSB-first two's-complement view of the bank being summed
    always_comb begin
        llr_tc  = sm_to_tc(llr_q[abank]);
        llr_bit = llr_tc[bit_idx];
        for (int e = 0; e < DEG; e++) begin
            msg_tc[e]  = fresh_q[abank] ? '0 : sm_to_tc(msg_q[abank][e]);
            msg_bit[e] = msg_tc[e][bit_idx];
        end
    end

    // operand set for each edge: channel plus all other edges
    always_comb begin
        for (int e = 0; e < DEG; e++) begin
            edge_ops[e][0] = llr_bit;
            for (int k = 0; k < DEG-1; k++)
                edge_ops[e][k+1] = msg_bit[(k < e) ? k : k+1];
        end
    end

    for (genvar e = 0; e < DEG; e++) begin : g_edge
        bsvn_col_add #(.NOPS(DEG), .MSG_W(MSG_W), .SW(SW)) u_add (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en),
            .st      (st),
            .op_bits (edge_ops[e]),
            .res_sm  (edge_res[e]),
            .neg     (edge_neg[e])
        );

        AST_EDGE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
            (en && st == ST_TAIL) |-> (edge_res[e][MSG_W-1] == edge_neg[e]));  // R6
    end

    bsvn_col_add #(.NOPS(DEG+1), .MSG_W(MSG_W), .SW(SW)) u_total (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .st      (st),
        .op_bits ({msg_bit, llr_bit}),
        .res_sm  (tot_res),
        .neg     (tot_neg)
    );

    // shared capture / result registers, channel latch, decisions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                llr_q[b] <= '0;
                for (int e = 0; e < DEG; e++) msg_q[b][e] <= '0;
            end
            fresh_q <= '0;
            hard_q  <= '0;
        end else if (en) begin
            for (int b = 0; b < 2; b++) begin
                for (int e = 0; e < DEG; e++) begin
                    if (1'(b) == side)
                        msg_q[b][e] <= {msg_q[b][e][MSG_W-2:0], c2v_bit[e]};
                    else if (st == ST_TAIL)
                        msg_q[b][e] <= edge_res[e];
                end
            end
            if (st == ST_HEAD) begin
                fresh_q[side] <= frame_go;
                if (frame_go) llr_q[side] <= llr_in;
            end
            if (st == ST_TAIL) hard_q[abank] <= tot_neg;
        end
    end

    always_comb begin
        for (int e = 0; e < DEG; e++) v2c_bit[e] = en & msg_q[side][e][MSG_W-1];
        hard_dec = hard_q;
    end

    AST_FREEZE_HARD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(hard_q));                                          // R8
    AST_FREEZE_LLR: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(llr_q[0]) && $stable(llr_q[1])));                 // R8
    AST_FRESH_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == ST_TAIL && fresh_q[abank])
            |=> (msg_q[side][0][LW-1:0] == llr_q[side][LW-1:0]));          // R4
    AST_FRESH_HARD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == ST_TAIL && fresh_q[abank] && llr_q[abank][LW-1:0] != '0)
            |=> (hard_q[side] == llr_q[side][MSG_W-1]));                   // R7
    AST_TOTAL_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == ST_TAIL) |-> (tot_res[MSG_W-1] == tot_neg));          // R7

endmodule

// File: tb/sim_bsvn_node.sv
module sim_bsvn_node;

    localparam int DEG = 4;
    localparam int MW  = 4;
    localparam int NV  = 12;

    // {frame start, channel, m3, m2, m1, m0}, all sign-magnitude
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 4'h3, 4'h7, 4'h7, 4'h7, 4'h7},  // side0 fresh +3 (R4)
        {1'b1, 4'hA, 4'hF, 4'hF, 4'hF, 4'hF},  // side1 fresh -2 (R4)
        {1'b0, 4'h6, 4'h0, 4'h9, 4'h2, 4'h1},  // mixed signs (R3)
        {1'b0, 4'h6, 4'h9, 4'h9, 4'h9, 4'hD},  // negative clip (R6)
        {1'b0, 4'h6, 4'h7, 4'h7, 4'h7, 4'h7},  // positive clip (R6)
        {1'b0, 4'h6, 4'h2, 4'h8, 4'h0, 4'h8},  // negative zero, zero total (R5 R7)
        {1'b1, 4'hD, 4'h3, 4'h3, 4'h3, 4'h3},  // side0 restart -5 (R9)
        {1'b0, 4'h6, 4'h1, 4'h1, 4'h1, 4'h1},  // side1 keeps -2 (R9)
        {1'b0, 4'h6, 4'h0, 4'h9, 4'h9, 4'h9},  // sum -8 -> -7 (R6)
        {1'b1, 4'h8, 4'hF, 4'hF, 4'hF, 4'hF},  // channel negative zero (R5)
        {1'b0, 4'h6, 4'h0, 4'h1, 4'h7, 4'h7},  // partial clip
        {1'b0, 4'h6, 4'h9, 4'h4, 4'h2, 4'hB}   // mixed on zero channel
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           en = 1'b1;
    logic           frame_go = 1'b0;
    logic [MW-1:0]  llr_in = '0;
    logic [DEG-1:0] c2v = '0;
    logic [DEG-1:0] v2c;
    logic [1:0]     hard;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    logic [MW-1:0]  exp_v [NV][DEG];
    logic           exp_h [NV];
    logic [MW-1:0]  lat [2];
    logic [MW-1:0]  got [DEG];
    logic [1:0]     got_h;

    always #10 clk = ~clk;

    bsvn_node #(.DEG(DEG), .MSG_W(MW)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .frame_go (frame_go),
        .llr_in   (llr_in),
        .c2v_bit  (c2v),
        .v2c_bit  (v2c),
        .hard_dec (hard)
    );

    function automatic int tc_val(input logic [MW-1:0] s);
        return s[MW-1] ? -int'(s[MW-2:0]) : int'(s[MW-2:0]);
    endfunction

    function automatic logic [MW-1:0] to_sm(input int v);
        int c;
        c = (v > 7) ? 7 : ((v < -7) ? -7 : v);
        return (c < 0) ? {1'b1, 3'(-c)} : {1'b0, 3'(c)};
    endfunction

    task automatic check_eq(input string tag, input int slot, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s slot %0d: actual %0d expected %0d", tag, slot, act, expv);
        end
    endtask

    // one slot: starts and ends at a falling edge
    task automatic run_slot(input logic [20:0] vec, input logic use_en);
        for (int c = 0; c < MW; c++) begin
            en = use_en;
            #1;
            for (int e = 0; e < DEG; e++) got[e][MW-1-c] = v2c[e];
            if (c == 0) got_h = hard;
            frame_go = vec[20];
            llr_in   = vec[19:16];
            for (int e = 0; e < DEG; e++) c2v[e] = vec[4*e + MW-1 - c];
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while in reset
        check_eq("R1 v2c in reset", -1, int'(v2c), 0);
        check_eq("R1 hard in reset", -1, int'(hard), 0);
        rst_n = 1'b1;
        lat[0] = '0;
        lat[1] = '0;

        for (int k = 0; k < NV + 2; k++) begin
            logic [20:0] vec;
            vec = (k < NV) ? VEC[k] : '0;
            if (k < NV) begin
                int s, tot;
                s = k % 2;
                if (vec[20]) lat[s] = vec[19:16];
                tot = tc_val(lat[s]);
                if (!vec[20])
                    for (int j = 0; j < DEG; j++) tot += tc_val(vec[4*j +: 4]);
                for (int e = 0; e < DEG; e++)
                    exp_v[k][e] = vec[20] ? to_sm(tc_val(lat[s]))
                                          : to_sm(tot - tc_val(vec[4*e +: 4]));
                exp_h[k] = (tot < 0);
            end
            run_slot(vec, 1'b1);
            if (k < 2) begin
                // R1: nothing real answered yet
                for (int e = 0; e < DEG; e++)
                    check_eq("R1 early answer", k, int'(got[e]), 0);
                check_eq("R1 early hard", k, int'(got_h), 0);
            end else begin
                // R2 R3 R4 R5 R6 R9: answer two slots later on the same edge
                for (int e = 0; e < DEG; e++)
                    check_eq("R3 answer (R2 R4 R5 R6 R9)", k, int'(got[e]), int'(exp_v[k-2][e]));
                check_eq("R7 hard decision", k, int'(got_h[k%2]), int'(exp_h[k-2]));
            end
        end

        // R8: freeze for two slots with a pending frame start
        run_slot({1'b1, 4'h6, 16'hFFFF}, 1'b0);
        check_eq("R7 hard side0 before freeze", 14, int'(got_h[0]), 1);
        check_eq("R7 hard side1 before freeze", 14, int'(got_h[1]), 0);
        for (int e = 0; e < DEG; e++) check_eq("R8 lines quiet", 14, int'(got[e]), 0);
        run_slot({1'b1, 4'h6, 16'hFFFF}, 1'b0);
        for (int e = 0; e < DEG; e++) check_eq("R8 lines quiet", 15, int'(got[e]), 0);
        check_eq("R8 hard held", 15, int'(got_h), 1);
        run_slot('0, 1'b1);
        for (int e = 0; e < DEG; e++) check_eq("R8 side0 kept", 16, int'(got[e]), int'(4'hD));
        check_eq("R8 hard kept", 16, int'(got_h), 1);
        run_slot('0, 1'b1);
        for (int e = 0; e < DEG; e++) check_eq("R8 frame start ignored", 17, int'(got[e]), 0);
        check_eq("R8 hard side1", 17, int'(got_h[1]), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule